// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block watches the error reports coming out of an ECC decoder on a memory read path. It records single-bit (correctable) and multi-bit (uncorrectable) events in flag bits that software clears by writing ones. It can raise an interrupt from those flags. For the first error after the flags were last clear, it keeps the failing address, the 64-bit data word and the syndrome. Single-bit events are not flagged one by one. They are counted against a programmable threshold, and only the event that reaches the threshold raises the flag. Each error type can be switched off at the detector.

The unit also sits on the write path with a debug injection stage. When injection is armed, two 32-bit masks are XORed into the write data and an 8-bit mask is XORed into the check bits. This lets software create known errors. All state is reached through a plain 32-bit register port with word addresses. Read data is registered and appears one cycle after the address is presented.

Register map (word address : content):
- 0: bit 0 selects a 32-bit data bus when 1.
- 1: flags, with bit 0 for single-bit and bit 1 for multi-bit. Writing 1 to a bit clears it.
- 2: detection off, with bit 0 for single-bit and bit 1 for multi-bit.
- 3: interrupt enable, with bit 0 for single-bit and bit 1 for multi-bit.
- 4: threshold in bits 23:16 (reset value 1) and the running count in bits 7:0.
- 5: captured address bits 31:0.
- 6: captured upper address bits.
- 7: captured data bits 63:32.
- 8: captured data bits 31:0.
- 9: captured syndrome in bits 15:0, with bit 31 set when the captured event was multi-bit.
- 10: injection mask for data bits 63:32.
- 11: injection mask for data bits 31:0.
- 12: injection control, with the check-bit mask in bits 7:0 and the arm bit in bit 8.

Any other address reads 0.

Top module: `memerr_monitor`

## Requirements
- R1: After reset the flags, the detection-off bits, the interrupt enables, the count and `irq` are 0, and the threshold field reads 1 (register 4 reads 0x00010000).
- R2: An enabled multi-bit event sets flag bit 1 at the clock edge that samples it.
- R3: Writing a 1 to a flag bit clears that bit and leaves the others unchanged. Writing 0xFFFFFFFF clears both bits.
- R4: With threshold T>0, each enabled single-bit event adds 1 to the count. The event that brings the count to T sets flag bit 0 and returns the count to 0. Writing register 4 loads the threshold and zeroes the count.
- R5: With threshold 0, single-bit events neither count nor set the flag.
- R6: A type whose detection-off bit is 1 neither sets its flag nor counts.
- R7: When a flag is raised while both flags are 0, the address, data and syndrome of that event are captured. The captures do not change again until both flags are 0.
- R8: With register 0 bit 0 at 0 (64-bit bus), the captured syndrome keeps only bits 7:0. With it at 1 (32-bit bus), it keeps bits 15:0.
- R9: When a single-bit event and a multi-bit event arrive in the same cycle, both flags may be set. The capture is marked multi-bit (register 9 bit 31 = 1).
- R10: `irq` is 1 exactly when some flag is set whose interrupt enable bit is set. It updates at the same edge as the flags and the enables.
- R11: Injection mask and control registers read back what was written. With the arm bit at 0, write data and check bits pass through unchanged with one cycle of latency.
- R12: With the arm bit at 1, the write data leaves XORed with {mask 63:32, mask 31:0} and the check bits leave XORed with control bits 7:0, one cycle after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| ev_valid | input | 1 | Decoder report valid |
| ev_sbe | input | 1 | Report carries a single-bit error |
| ev_mbe | input | 1 | Report carries a multi-bit error |
| ev_addr | input | ADDR_W | Address of the reported read |
| ev_data | input | 64 | Data of the reported read |
| ev_syn | input | 16 | Syndrome of the reported read |
| wr_data_in | input | 64 | Write data before injection |
| wr_ecc_in | input | 8 | Check bits before injection |
| wr_data_out | output | 64 | Write data after injection, registered |
| wr_ecc_out | output | 8 | Check bits after injection, registered |
| irq | output | 1 | Interrupt, registered |

## Verification
A count that has drifted shows up as a flag that rises one or more events early or late in a threshold sweep. It is visible at the first read of register 4 or register 1 after the wrong event. Capture registers that are not held would be overwritten by the second event of a pair, so the fault shows at the next capture read. A wrong interrupt mask or flag shows on `irq` at the very edge where the flag or enable changes. Injection faults corrupt `wr_data_out` on the cycle after the pattern enters.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  typedef enum logic [3:0] {
    RG_CFG  = 4'd0,
    RG_DET  = 4'd1,
    RG_DIS  = 4'd2,
    RG_IEN  = 4'd3,
    RG_SBM  = 4'd4,
    RG_CADR = 4'd5,
    RG_CADX = 4'd6,
    RG_CDHI = 4'd7,
    RG_CDLO = 4'd8,
    RG_CECC = 4'd9,
    RG_IHI  = 4'd10,
    RG_ILO  = 4'd11,
    RG_ICTL = 4'd12
  } reg_idx_e;

  localparam int WORD_W = 32;
  localparam int DATA_W = 2 * WORD_W;
  localparam int F_SBE  = 0;
  localparam int F_MBE  = 1;
endpackage

// File: rtl/memerr_sbe_count.sv
module memerr_sbe_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_wdata,
  input  logic             sbe_in,
  output logic [CNT_W-1:0] thr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic [CNT_W:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hit = sbe_in && (thr_q != '0) && (cnt_inc == {1'b0, thr_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= CNT_W'(1);
      cnt_q <= '0;
    end else if (thr_wr) begin
      thr_q <= thr_wdata;
      cnt_q <= '0;
    end else if (sbe_in && (thr_q != '0)) begin
      cnt_q <= hit ? '0 : cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture #(
  parameter int ADDR_W = 36,
  parameter int SYN_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              bus32,
  input  logic              is_mbe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [SYN_W-1:0]  syn,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [SYN_W-1:0]  cap_syn,
  output logic              cap_mbe
);
  localparam int NARROW_W = SYN_W / 2;

  logic [SYN_W-1:0] syn_m;

  assign syn_m = bus32 ? syn : {{(SYN_W-NARROW_W){1'b0}}, syn[NARROW_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_syn  <= '0;
      cap_mbe  <= 1'b0;
    end else if (take) begin
      cap_addr <= addr;
      cap_data <= data;
      cap_syn  <= syn_m;
      cap_mbe  <= is_mbe;
    end
  end
endmodule

// File: rtl/memerr_inject.sv
module memerr_inject #(
  parameter int WORD_W = 32,
  parameter int ECC_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic                wr_ctl,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [2*WORD_W-1:0] data_in,
  input  logic [ECC_W-1:0]    ecc_in,
  output logic [2*WORD_W-1:0] data_out,
  output logic [ECC_W-1:0]    ecc_out,
  output logic [WORD_W-1:0]   mask_hi,
  output logic [WORD_W-1:0]   mask_lo,
  output logic [ECC_W:0]      ctl_q,
  output logic                armed
);
  assign armed = ctl_q[ECC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi <= '0;
      mask_lo <= '0;
      ctl_q   <= '0;
    end else begin
      if (wr_hi)  mask_hi <= wdata;
      if (wr_lo)  mask_lo <= wdata;
      if (wr_ctl) ctl_q   <= wdata[ECC_W:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      ecc_out  <= '0;
    end else if (armed) begin
      data_out <= data_in ^ {mask_hi, mask_lo};
      ecc_out  <= ecc_in ^ ctl_q[ECC_W-1:0];
    end else begin
      data_out <= data_in;
      ecc_out  <= ecc_in;
    end
  end
endmodule

// File: rtl/memerr_monitor.sv
module memerr_monitor
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int THR_W  = 8,
  parameter int SYN_W  = 16,
  parameter int ECC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_valid,
  input  logic              ev_sbe,
  input  logic              ev_mbe,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [63:0]       ev_data,
  input  logic [15:0]       ev_syn,
  input  logic [63:0]       wr_data_in,
  input  logic [7:0]        wr_ecc_in,
  output logic [63:0]       wr_data_out,
  output logic [7:0]        wr_ecc_out,
  output logic              irq
);
  localparam int EXT_W = ADDR_W - WORD_W;
  localparam int THR_LSB = 16;

  logic              cfg_bus32;
  logic [1:0]        det_q, dis_q, ien_q;
  logic [1:0]        det_next, ien_next, det_clr;
  logic              sbe_ok, mbe_ok, sbe_hit, take;
  logic [THR_W-1:0]  thr_q, cnt_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [63:0]       cap_data;
  logic [SYN_W-1:0]  cap_syn;
  logic              cap_mbe;
  logic [31:0]       mask_hi, mask_lo;
  logic [ECC_W:0]    inj_ctl;
  logic              inj_armed;
  logic              wr_det, wr_ien, wr_sbm;

  assign wr_det = reg_we && (reg_addr == RG_DET);
  assign wr_ien = reg_we && (reg_addr == RG_IEN);
  assign wr_sbm = reg_we && (reg_addr == RG_SBM);

  assign sbe_ok = ev_valid && ev_sbe && !dis_q[F_SBE];
  assign mbe_ok = ev_valid && ev_mbe && !dis_q[F_MBE];

  memerr_sbe_count #(.CNT_W(THR_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .thr_wr    (wr_sbm),
    .thr_wdata (reg_wdata[THR_LSB +: THR_W]),
    .sbe_in    (sbe_ok),
    .thr_q     (thr_q),
    .cnt_q     (cnt_q),
    .hit       (sbe_hit)
  );

  // a raised flag with nothing pending starts a capture; multi-bit marks it
  assign take = (det_q == 2'b00) && (sbe_hit || mbe_ok);

  memerr_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .bus32    (cfg_bus32),
    .is_mbe   (mbe_ok),
    .addr     (ev_addr),
    .data     (ev_data),
    .syn      (ev_syn),
    .cap_addr (cap_addr),
    .cap_data (cap_data),
    .cap_syn  (cap_syn),
    .cap_mbe  (cap_mbe)
  );

  memerr_inject #(.WORD_W(WORD_W), .ECC_W(ECC_W)) u_inj (
    .clk      (clk),
    .rst      (rst),
    .wr_hi    (reg_we && (reg_addr == RG_IHI)),
    .wr_lo    (reg_we && (reg_addr == RG_ILO)),
    .wr_ctl   (reg_we && (reg_addr == RG_ICTL)),
    .wdata    (reg_wdata),
    .data_in  (wr_data_in),
    .ecc_in   (wr_ecc_in),
    .data_out (wr_data_out),
    .ecc_out  (wr_ecc_out),
    .mask_hi  (mask_hi),
    .mask_lo  (mask_lo),
    .ctl_q    (inj_ctl),
    .armed    (inj_armed)
  );

  // new events win over a same-cycle clear
  assign det_clr  = wr_det ? reg_wdata[1:0] : 2'b00;
  assign det_next = (det_q & ~det_clr) | {mbe_ok, sbe_hit};
  assign ien_next = wr_ien ? reg_wdata[1:0] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_bus32 <= 1'b0;
      det_q     <= '0;
      dis_q     <= '0;
      ien_q     <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == RG_CFG)) cfg_bus32 <= reg_wdata[0];
      if (reg_we && (reg_addr == RG_DIS)) dis_q <= reg_wdata[1:0];
      det_q <= det_next;
      ien_q <= ien_next;
      irq   <= |(det_next & ien_next);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RG_CFG:  reg_rdata <= {31'b0, cfg_bus32};
        RG_DET:  reg_rdata <= {30'b0, det_q};
        RG_DIS:  reg_rdata <= {30'b0, dis_q};
        RG_IEN:  reg_rdata <= {30'b0, ien_q};
        RG_SBM:  reg_rdata <= 32'({thr_q, 8'b0, cnt_q});
        RG_CADR: reg_rdata <= cap_addr[31:0];
        RG_CADX: reg_rdata <= 32'(cap_addr[ADDR_W-1 -: EXT_W]);
        RG_CDHI: reg_rdata <= cap_data[63:32];
        RG_CDLO: reg_rdata <= cap_data[31:0];
        RG_CECC: reg_rdata <= {cap_mbe, 15'b0, cap_syn};
        RG_IHI:  reg_rdata <= mask_hi;
        RG_ILO:  reg_rdata <= mask_lo;
        RG_ICTL: reg_rdata <= 32'(inj_ctl);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/memerr_monitor_chk.sv
module memerr_monitor_chk #(
  parameter int ADDR_W = 36,
  parameter int THR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_mbe,
  input logic [1:0]        det_q,
  input logic [1:0]        dis_q,
  input logic [THR_W-1:0]  thr_q,
  input logic [THR_W-1:0]  cnt_q,
  input logic [63:0]       cap_data,
  input logic [ADDR_W-1:0] cap_addr,
  input logic              inj_armed,
  input logic [63:0]       wr_data_in,
  input logic [63:0]       wr_data_out,
  input logic              irq
);
  // R2
  a_r2_mbe_flags: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_mbe && !dis_q[1]) |=> det_q[1]);

  // R4
  a_r4_count_below_thr: assert property (@(posedge clk) disable iff (rst)
    (thr_q == '0) ? (cnt_q == '0) : (cnt_q < thr_q));

  // R7
  a_r7_capture_held: assert property (@(posedge clk) disable iff (rst)
    (det_q != 2'b00) |=> ($stable(cap_data) && $stable(cap_addr)));

  // R10
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (det_q != 2'b00));

  // R11
  a_r11_passthrough: assert property (@(posedge clk) disable iff (rst)
    !inj_armed |=> (wr_data_out == $past(wr_data_in)));
endmodule

bind memerr_monitor memerr_monitor_chk #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_valid    (ev_valid),
  .ev_mbe      (ev_mbe),
  .det_q       (det_q),
  .dis_q       (dis_q),
  .thr_q       (thr_q),
  .cnt_q       (cnt_q),
  .cap_data    (cap_data),
  .cap_addr    (cap_addr),
  .inj_armed   (inj_armed),
  .wr_data_in  (wr_data_in),
  .wr_data_out (wr_data_out),
  .irq         (irq)
);

// File: tb/memerr_monitor_test.sv
module memerr_monitor_test;
  localparam int ADDR_W = 36;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              ev_valid = 1'b0, ev_sbe = 1'b0, ev_mbe = 1'b0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic [63:0]       ev_data = '0;
  logic [15:0]       ev_syn = '0;
  logic [63:0]       wr_data_in = '0;
  logic [7:0]        wr_ecc_in = '0;
  logic [63:0]       wr_data_out;
  logic [7:0]        wr_ecc_out;
  logic              irq;

  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  memerr_monitor #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_syn(ev_syn), .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in),
    .wr_data_out(wr_data_out), .wr_ecc_out(wr_ecc_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic event_in(input logic s, input logic m, input logic [ADDR_W-1:0] a,
                          input logic [63:0] dat, input logic [15:0] sy);
    @(negedge clk);
    ev_valid = 1'b1; ev_sbe = s; ev_mbe = m; ev_addr = a; ev_data = dat; ev_syn = sy;
    @(negedge clk);
    ev_valid = 1'b0; ev_sbe = 1'b0; ev_mbe = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rreg(4'd1, rv);  chk("R1 flags", rv, 0);
    rreg(4'd2, rv);  chk("R1 disable", rv, 0);
    rreg(4'd3, rv);  chk("R1 inten", rv, 0);
    rreg(4'd4, rv);  chk("R1 threshold", rv, 32'h0001_0000);
    chk("R1 irq", irq, 0);

    // R2 multi-bit flag, R10 irq follows enable
    event_in(1'b0, 1'b1, 36'h1_0000_0040, 64'h0, 16'h0);
    chk("R2 irq with enable off", irq, 0);
    rreg(4'd1, rv);  chk("R2 mbe flag", rv, 32'h2);
    wreg(4'd3, 32'h2);
    chk("R10 irq after enabling", irq, 1);
    wreg(4'd3, 32'h1);
    chk("R10 irq masked by other enable", irq, 0);
    wreg(4'd3, 32'h3);

    // R3 write-one-to-clear
    event_in(1'b1, 1'b0, '0, 64'h0, 16'h0);   // threshold 1: sets sbe flag
    rreg(4'd1, rv);  chk("R3 both set", rv, 32'h3);
    wreg(4'd1, 32'h2);
    rreg(4'd1, rv);  chk("R3 clear mbe only", rv, 32'h1);
    chk("R10 irq still on sbe", irq, 1);
    wreg(4'd1, 32'hFFFF_FFFF);
    rreg(4'd1, rv);  chk("R3 clear all", rv, 32'h0);
    chk("R10 irq off", irq, 0);

    // R4 threshold sweep
    for (int t = 1; t <= 6; t++) begin
      wreg(4'd4, t << 16);
      for (int k = 0; k < t - 1; k++) event_in(1'b1, 1'b0, '0, 64'h0, 16'h0);
      rreg(4'd1, rv);  chk("R4 no flag below threshold", rv, 0);
      rreg(4'd4, rv);  chk("R4 count", rv, (t << 16) | (t - 1));
      event_in(1'b1, 1'b0, '0, 64'h0, 16'h0);
      chk("R10 irq at threshold", irq, 1);
      rreg(4'd1, rv);  chk("R4 flag at threshold", rv, 32'h1);
      rreg(4'd4, rv);  chk("R4 count wraps", rv, t << 16);
      wreg(4'd1, 32'h3);
    end

    // R5 threshold zero
    wreg(4'd4, 32'h0);
    for (int k = 0; k < 10; k++) event_in(1'b1, 1'b0, '0, 64'h0, 16'h0);
    rreg(4'd1, rv);  chk("R5 no flag", rv, 0);
    rreg(4'd4, rv);  chk("R5 no count", rv, 0);

    // R6 detection off
    wreg(4'd4, 32'h0002_0000);
    wreg(4'd2, 32'h3);
    for (int k = 0; k < 4; k++) event_in(1'b1, 1'b1, '0, 64'h0, 16'h0);
    rreg(4'd1, rv);  chk("R6 flags off", rv, 0);
    rreg(4'd4, rv);  chk("R6 count off", rv, 32'h0002_0000);
    wreg(4'd2, 32'h1);
    event_in(1'b1, 1'b1, '0, 64'h0, 16'h0);
    rreg(4'd1, rv);  chk("R6 only mbe", rv, 32'h2);
    wreg(4'd2, 32'h0);
    wreg(4'd1, 32'h3);
    wreg(4'd4, 32'h0001_0000);

    // R7 capture of the first event, R8 64-bit syndrome width
    event_in(1'b1, 1'b0, 36'hA_1234_5678, 64'hDEAD_BEEF_0123_4567, 16'hABCD);
    event_in(1'b0, 1'b1, 36'h5_FFFF_0000, 64'h1111_2222_3333_4444, 16'h5555);
    rreg(4'd5, rv);  chk("R7 addr low", rv, 32'h1234_5678);
    rreg(4'd6, rv);  chk("R7 addr ext", rv, 32'hA);
    rreg(4'd7, rv);  chk("R7 data hi", rv, 32'hDEAD_BEEF);
    rreg(4'd8, rv);  chk("R7 data lo", rv, 32'h0123_4567);
    rreg(4'd9, rv);  chk("R8 syndrome 64-bit", rv, 32'h0000_00CD);
    rreg(4'd1, rv);  chk("R7 both flags", rv, 32'h3);

    // R8 32-bit width, R9 same-cycle priority
    wreg(4'd1, 32'h3);
    wreg(4'd0, 32'h1);
    event_in(1'b1, 1'b1, 36'h0_0000_0100, 64'h0F0F_0F0F_F0F0_F0F0, 16'hABCD);
    rreg(4'd9, rv);  chk("R9 R8 mbe marked, 16-bit syndrome", rv, 32'h8000_ABCD);
    rreg(4'd1, rv);  chk("R9 both flags", rv, 32'h3);
    rreg(4'd8, rv);  chk("R7 new capture after clear", rv, 32'hF0F0_F0F0);
    wreg(4'd1, 32'h3);

    // R11 readback and pass-through
    wreg(4'd10, 32'h8000_0001);
    wreg(4'd11, 32'h0000_0100);
    wreg(4'd12, 32'h0000_0081);
    rreg(4'd10, rv); chk("R11 mask hi", rv, 32'h8000_0001);
    rreg(4'd11, rv); chk("R11 mask lo", rv, 32'h0000_0100);
    rreg(4'd12, rv); chk("R11 ctl", rv, 32'h0000_0081);
    for (int i = 0; i < 8; i++) begin
      logic [63:0] p;
      p = 64'h0123_4567_89AB_CDEF * (i + 1);
      @(negedge clk);
      wr_data_in = p; wr_ecc_in = 8'(i * 37);
      @(negedge clk);
      chk("R11 data pass", wr_data_out, p);
      chk("R11 ecc pass", {56'h0, wr_ecc_out}, {56'h0, 8'(i * 37)});
    end

    // R12 armed injection
    wreg(4'd12, 32'h0000_0181);
    for (int i = 0; i < 8; i++) begin
      logic [63:0] p;
      p = 64'hFEDC_BA98_7654_3210 + i * 64'h1_0001;
      @(negedge clk);
      wr_data_in = p; wr_ecc_in = 8'(i * 19);
      @(negedge clk);
      chk("R12 data xor", wr_data_out, p ^ 64'h8000_0001_0000_0100);
      chk("R12 ecc xor", {56'h0, wr_ecc_out}, {56'h0, 8'(i * 19) ^ 8'h81});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule